// File: doc/BRIEF.md
# Mailbox Request Parser and Responder

This block serves one side of a narrow mailbox: software writes every dword of a request into the same inbound FIFO and then strobes `go`. The block then pulls the request out of that FIFO one dword per cycle and checks the four framing dwords. It passes the payload dwords, in order, to a downstream stream port that uses valid/ready handshaking. Last, it writes a four-dword reply into the outbound FIFO and raises a ready flag, with an error flag beside it.

The reply tells software how far the transfer has got. The block keeps a running byte count of all payload accepted across requests. Once that count reaches a configurable image size, the reply reports an all-ones offset to say the transfer is finished. A malformed request is not forwarded. The block drains every dword that was present when `go` arrived, replies with the error flag, and raises the error status.

Top module: `mbox_req_engine`

## Requirements
- R1: After reset `stat_ready` and `stat_error` are 0, and `in_rd`, `out_wr` and `pay_valid` are all 0.
- R2: A request is well formed only under four conditions. Dword 0 must equal {16'h000B, VENDOR_ID}, with the object type in bits 31:16 and the vendor identifier in bits 15:0. Dword 1 is the length L, which must satisfy 4 <= L <= the inbound count seen at `go`. Dword 2 must equal 3 (load), and dword 3 must equal 0.
- R3: For a well-formed request, exactly L-4 payload dwords go out on `pay_data` in FIFO order, one on each cycle with `pay_valid && pay_ready`. While `pay_ready` is low, `pay_valid` stays high and `pay_data` stays stable. Dwords beyond L stay in the inbound FIFO.
- R4: Each request gets exactly four `out_wr` writes on consecutive cycles, in this order: the dword-0 header value, the value 4, the offset word, the flag word. No inbound dword is popped while the reply is written.
- R5: The flag word sets exactly one bit and leaves all other bits 0. Bit 0 means success, a good request after the transfer is finished. Bit 1 means in progress, a good request before that point. Bit 2 means error.
- R6: The offset word is the total payload bytes accepted since reset, at 4 bytes per dword. Once that total reaches IMG_BYTES, the offset word is 32'hFFFFFFFF.
- R7: A malformed request pops and discards every dword counted at `go`, forwards no payload and answers with flag bit 2. `stat_error` then reads 1 together with `stat_ready`.
- R8: A `go` with fewer than 4 dwords available, or with fewer dwords available than L, is a malformed request. The block never pops an empty inbound FIFO.
- R9: `stat_ready` is 0 from the cycle after an accepted `go`. It rises in the cycle after the fourth reply write.
- R10: A `go` that arrives while a request is being handled is ignored and causes no second reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, one cycle |
| in_count | input | CNT_W | Dwords currently held in the inbound FIFO |
| in_data | input | 32 | Head dword of the inbound FIFO (show-ahead) |
| in_rd | output | 1 | Pop the inbound FIFO head |
| pay_valid | output | 1 | Payload dword valid |
| pay_ready | input | 1 | Downstream accepts payload |
| pay_data | output | 32 | Payload dword |
| out_wr | output | 1 | Write strobe into the outbound FIFO |
| out_data | output | 32 | Reply dword |
| stat_ready | output | 1 | Reply complete |
| stat_error | output | 1 | Last request was malformed (valid with ready) |

## Verification
A wrong parser state shows up at the ports within a cycle or two. A stuck or skipped header index makes `in_rd` pop too few or too many dwords, which changes the inbound count left after the request and adds or loses payload beats. A wrong byte counter or done flag corrupts the third or fourth reply dword of the very next reply. A response counter that wraps early or late gives the wrong number of `out_wr` writes, and `stat_ready` then rises one cycle off from the last write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [15:0] OBJ_STAGE = 16'h000B;
  localparam logic [31:0] CMD_LOAD  = 32'h0000_0003;
  localparam logic [31:0] HDR_DW    = 32'd4;
  localparam logic [31:0] OFFS_END  = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PAY, ST_DRAIN, ST_RESP} eng_st_t;

  function automatic logic [31:0] hdr_word(input logic [15:0] vid);
    return {OBJ_STAGE, vid};
  endfunction

  function automatic logic [31:0] flag_word(input logic err, input logic done);
    if (err)       return 32'h4;
    else if (done) return 32'h1;
    else           return 32'h2;
  endfunction

  function automatic logic [31:0] offs_word(input logic [31:0] bytes, input logic [31:0] lim);
    return (bytes >= lim) ? OFFS_END : bytes;
  endfunction
endpackage

// File: rtl/mbox_frame_check.sv
module mbox_frame_check
  import mbox_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h5A3C,
  parameter int          CNT_W     = 16
) (
  input  logic [1:0]       idx,
  input  logic [31:0]      word,
  input  logic [CNT_W-1:0] avail,
  output logic             bad
);
  always_comb begin
    unique case (idx)
      2'd0:    bad = (word != hdr_word(VENDOR_ID));
      2'd1:    bad = (word < HDR_DW) || (word > 32'(avail));
      2'd2:    bad = (word != CMD_LOAD);
      default: bad = (word != 32'd0);
    endcase
  end
endmodule

// File: rtl/mbox_offset_acc.sv
module mbox_offset_acc
  import mbox_pkg::*;
#(
  parameter int IMG_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inc,
  output logic [31:0] offs,
  output logic        done
);
  localparam logic [31:0] LIM = 32'(IMG_BYTES);

  logic [31:0] bytes_q;

  assign done = (bytes_q >= LIM);
  assign offs = offs_word(bytes_q, LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)           bytes_q <= '0;
    else if (inc && !done) bytes_q <= bytes_q + 32'd4;
  end
endmodule

// File: rtl/mbox_resp_mux.sv
module mbox_resp_mux
  import mbox_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h5A3C
) (
  input  logic [1:0]  idx,
  input  logic        err,
  input  logic        done,
  input  logic [31:0] offs,
  output logic [31:0] word
);
  always_comb begin
    unique case (idx)
      2'd0:    word = hdr_word(VENDOR_ID);
      2'd1:    word = HDR_DW;
      2'd2:    word = offs;
      default: word = flag_word(err, done);
    endcase
  end
endmodule

// File: rtl/mbox_req_engine.sv
module mbox_req_engine
  import mbox_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h5A3C,
  parameter int          IMG_BYTES = 64,
  parameter int          CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] in_count,
  input  logic [31:0]      in_data,
  output logic             in_rd,
  output logic             pay_valid,
  input  logic             pay_ready,
  output logic [31:0]      pay_data,
  output logic             out_wr,
  output logic [31:0]      out_data,
  output logic             stat_ready,
  output logic             stat_error
);
  localparam logic [CNT_W-1:0] HDR_CNT = CNT_W'(4);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  eng_st_t          st_q;
  logic [1:0]       idx_q;
  logic [CNT_W-1:0] snap_q, left_q, plen_q;
  logic             err_q, ready_q, error_q;

  // named internal events
  logic        hdr_bad, pay_fire, resp_last, busy, acc_done;
  logic [31:0] acc_offs;

  assign busy      = (st_q != ST_IDLE);
  assign pay_fire  = (st_q == ST_PAY) && pay_ready;
  assign resp_last = (st_q == ST_RESP) && (idx_q == 2'd3);

  mbox_frame_check #(.VENDOR_ID(VENDOR_ID), .CNT_W(CNT_W)) u_chk_frame (
    .idx(idx_q), .word(in_data), .avail(snap_q), .bad(hdr_bad)
  );

  mbox_offset_acc #(.IMG_BYTES(IMG_BYTES)) u_offs (
    .clk(clk), .rst_n(rst_n), .inc(pay_fire), .offs(acc_offs), .done(acc_done)
  );

  mbox_resp_mux #(.VENDOR_ID(VENDOR_ID)) u_resp (
    .idx(idx_q), .err(err_q), .done(acc_done), .offs(acc_offs), .word(out_data)
  );

  assign in_rd      = (st_q == ST_HDR) || (st_q == ST_DRAIN) || pay_fire;
  assign pay_valid  = (st_q == ST_PAY);
  assign pay_data   = in_data;
  assign out_wr     = (st_q == ST_RESP);
  assign stat_ready = ready_q;
  assign stat_error = error_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      snap_q  <= '0;
      left_q  <= '0;
      plen_q  <= '0;
      err_q   <= 1'b0;
      ready_q <= 1'b0;
      error_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          ready_q <= 1'b0;
          error_q <= 1'b0;
          snap_q  <= in_count;
          left_q  <= in_count;
          idx_q   <= '0;
          if (in_count < HDR_CNT) begin
            err_q <= 1'b1;
            st_q  <= (in_count == '0) ? ST_RESP : ST_DRAIN;
          end else begin
            err_q <= 1'b0;
            st_q  <= ST_HDR;
          end
        end
        ST_HDR: begin
          left_q <= left_q - ONE;
          if (hdr_bad) begin
            err_q <= 1'b1;
            idx_q <= '0;
            st_q  <= (left_q == ONE) ? ST_RESP : ST_DRAIN;
          end else begin
            idx_q <= idx_q + 2'd1;
            if (idx_q == 2'd1) plen_q <= CNT_W'(in_data) - HDR_CNT;
            if (idx_q == 2'd3) st_q <= (plen_q == '0) ? ST_RESP : ST_PAY;
          end
        end
        ST_PAY: if (pay_ready) begin
          left_q <= left_q - ONE;
          plen_q <= plen_q - ONE;
          if (plen_q == ONE) st_q <= ST_RESP;
        end
        ST_DRAIN: begin
          left_q <= left_q - ONE;
          if (left_q == ONE) st_q <= ST_RESP;
        end
        ST_RESP: begin
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            st_q    <= ST_IDLE;
            ready_q <= 1'b1;
            error_q <= err_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_req_engine_chk.sv
module mbox_req_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] in_count,
  input logic             in_rd,
  input logic             pay_valid,
  input logic             pay_ready,
  input logic [31:0]      pay_data,
  input logic             out_wr,
  input logic [31:0]      out_data,
  input logic             stat_ready,
  input logic             stat_error,
  input logic             resp_last,
  input logic             busy
);
  a_r3_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid && !pay_ready |=> pay_valid && $stable(pay_data));

  a_r8_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |-> in_count != '0);

  a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    resp_last |-> ($countones(out_data[2:0]) == 1) && (out_data[31:3] == '0));

  a_r9_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ready) |-> $past(resp_last));

  a_r7_error_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    stat_error |-> stat_ready);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stat_ready);

  a_r4_resp_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> !in_rd && !pay_valid);
endmodule

bind mbox_req_engine mbox_req_engine_chk #(.CNT_W(CNT_W)) u_bound_chk (
  .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_rd(in_rd),
  .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
  .out_wr(out_wr), .out_data(out_data), .stat_ready(stat_ready),
  .stat_error(stat_error), .resp_last(resp_last), .busy(busy)
);

// File: tb/mbox_req_engine_test.sv
`timescale 1ns/1ps
module mbox_req_engine_test;
  localparam logic [15:0] VID   = 16'h5A3C;
  localparam int          IMG   = 64;
  localparam int          CNT_W = 16;
  localparam logic [31:0] HDR   = {16'h000B, VID};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, go = 1'b0, pay_ready = 1'b1;
  logic [CNT_W-1:0] in_count;
  logic [31:0] in_data, pay_data, out_data;
  logic in_rd, pay_valid, out_wr, stat_ready, stat_error;

  mbox_req_engine #(.VENDOR_ID(VID), .IMG_BYTES(IMG), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .in_count(in_count), .in_data(in_data),
    .in_rd(in_rd), .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_wr(out_wr), .out_data(out_data), .stat_ready(stat_ready), .stat_error(stat_error)
  );

  // behavioural inbound FIFO
  logic [31:0] mem [0:511];
  int wr_ptr = 0;
  int rd_ptr = 0;
  assign in_data  = mem[rd_ptr[8:0]];
  assign in_count = CNT_W'(wr_ptr - rd_ptr);
  always @(posedge clk) if (in_rd) rd_ptr <= rd_ptr + 1;

  int checks = 0, errors = 0, cyc = 0, stall_mode = 0;
  logic [31:0] pay_q[$];
  logic [31:0] resp_q[$];
  bit ready_due = 0, req_done = 0, exp_err = 0;
  longint model_bytes = 0;
  int seed = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pay_ready <= (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // per-cycle comparison against the reference queues
  always @(negedge clk) if (rst_n) begin
    if (out_wr) begin
      if (resp_q.size() == 0) chk(0, "R4 unexpected reply write", out_data, 32'h0);
      else begin
        logic [31:0] e;
        e = resp_q.pop_front();
        chk(out_data == e, "R4 R5 R6 reply word", out_data, e);
        if (resp_q.size() == 0) ready_due = 1;
      end
    end else if (ready_due) begin
      chk(stat_ready == 1'b1, "R9 ready after last write", 32'(stat_ready), 32'h1);
      chk(stat_error == exp_err, "R7 error status", 32'(stat_error), 32'(exp_err));
      ready_due = 0;
      req_done  = 1;
    end
    if (pay_valid && pay_ready) begin
      if (pay_q.size() == 0) chk(0, "R3 unexpected payload beat", pay_data, 32'h0);
      else begin
        logic [31:0] p;
        p = pay_q.pop_front();
        chk(pay_data == p, "R3 payload order", pay_data, p);
      end
    end
  end

  task automatic send(input logic [31:0] hdr, input logic [31:0] len, input logic [31:0] cmd,
                      input logic [31:0] rsv, input int npay, input int npush,
                      input int extra, input bit e, input bit busy_go);
    logic [31:0] w[$];
    logic [31:0] ow;
    w = {hdr, len, cmd, rsv};
    for (int i = 0; i < npay; i++) begin
      w.push_back(32'hC000_0000 + 32'(seed));
      seed++;
    end
    for (int i = 0; i < npush; i++) begin
      mem[wr_ptr[8:0]] = w[i];
      wr_ptr++;
    end
    for (int i = 0; i < extra; i++) begin
      mem[wr_ptr[8:0]] = 32'hEEEE_0000 + 32'(i);
      wr_ptr++;
    end
    if (!e) begin
      for (int i = 0; i < npay; i++) pay_q.push_back(w[4+i]);
      model_bytes += 4 * npay;
    end
    ow = (model_bytes >= IMG) ? 32'hFFFF_FFFF : 32'(model_bytes);
    resp_q.push_back(HDR);
    resp_q.push_back(32'd4);
    resp_q.push_back(ow);
    resp_q.push_back(e ? 32'h4 : ((model_bytes >= IMG) ? 32'h1 : 32'h2));
    exp_err  = e;
    req_done = 0;
    @(posedge clk); #1 go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
    @(negedge clk);
    chk(stat_ready == 1'b0, "R9 ready cleared after go", 32'(stat_ready), 32'h0);
    for (int n = 0; n < 400 && !req_done; n++) begin
      @(posedge clk); #1;
      go = (busy_go && n == 3);   // R10: go while busy
    end
    go = 1'b0;
    chk(req_done, "R9 reply completed", 32'(req_done), 32'h1);
    repeat (3) @(negedge clk);
    chk(resp_q.size() == 0, "R10 R4 reply count", 32'(resp_q.size()), 32'h0);
    chk(pay_q.size() == 0, "R3 payload count", 32'(pay_q.size()), 32'h0);
    chk(in_count == CNT_W'(e ? 0 : extra), e ? "R7 drained all words" : "R3 words past length kept",
        32'(in_count), 32'(e ? 0 : extra));
    wr_ptr = rd_ptr;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat_ready == 0 && stat_error == 0, "R1 reset status", {30'd0, stat_ready, stat_error}, 32'h0);
    chk(!in_rd && !out_wr && !pay_valid, "R1 reset strobes", {29'd0, in_rd, out_wr, pay_valid}, 32'h0);

    send(HDR, 32'd7, 32'd3, 32'd0, 3, 7, 0, 0, 0);          // R2 R6 good, offset 12
    stall_mode = 1;
    send(HDR, 32'd6, 32'd3, 32'd0, 2, 6, 2, 0, 0);          // R3 stalls, extras kept
    send(HDR, 32'd4, 32'd3, 32'd0, 0, 4, 0, 0, 0);          // R3 no payload
    send(HDR ^ 32'h1, 32'd6, 32'd3, 32'd0, 2, 6, 3, 1, 0);  // R2 R7 bad header
    send(HDR, 32'd5, 32'd2, 32'd0, 1, 5, 0, 1, 0);          // R2 bad command
    send(HDR, 32'd5, 32'd3, 32'd1, 1, 5, 0, 1, 0);          // R2 nonzero reserved
    send(HDR, 32'd3, 32'd3, 32'd0, 0, 4, 0, 1, 0);          // R2 length below 4
    send(HDR, 32'd8, 32'd3, 32'd0, 4, 6, 0, 1, 0);          // R8 fewer than length
    send(HDR, 32'd8, 32'd3, 32'd0, 4, 2, 0, 1, 0);          // R8 fewer than four
    send(HDR, 32'd6, 32'd3, 32'd0, 2, 6, 0, 0, 1);          // R10 go while busy
    stall_mode = 0;
    send(HDR, 32'd14, 32'd3, 32'd0, 10, 14, 0, 0, 0);       // R6 R5 reaches image size
    send(HDR, 32'd5, 32'd3, 32'd0, 1, 5, 0, 0, 0);          // R5 success after done
    send(HDR, 32'd5, 32'd9, 32'd0, 1, 5, 0, 1, 0);          // R6 error after done

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule